// File: doc/BRIEF.md
# Cached-Head Ring Buffer Controller

This block is a four-entry first-in first-out queue of 2-bit values. The oldest entry always sits in a local head register that drives the output port directly, so the consumer sees it without waiting on storage. Entries behind the head are parked in three external storage cells. The controller reaches those cells through a write handshake and a read handshake, each carrying a cell index in the range 1 to 3.

The producer and consumer sides use valid/ready handshakes. A push into an empty queue lands directly in the head register and touches no cell. A push into a non-empty queue becomes a cell write at the write pointer. A pop that leaves entries behind triggers a cell read at the read pointer, and the returned value refills the head. While a cell transaction is outstanding, the controller accepts neither a push nor a pop.

Top module: `ringbuf_ctrl`

## Requirements
- R1: After synchronous active-high reset, out_valid is 0, in_ready is 1, no cell request is raised, and both ring pointers are at index 1.
- R2: Values leave in the order they were accepted. out_valid is 1 exactly when the queue holds at least one entry and no cell transaction is outstanding. out_data does not change while out_valid is 1 and out_ready is 0.
- R3: A push accepted while the queue is empty raises no cell write. In the next cycle, out_valid is 1 and out_data equals the pushed value.
- R4: A push accepted while the queue is non-empty raises wr_req in the next cycle, with wr_idx equal to the write pointer and wr_data equal to the pushed value. The pointer advances on the acknowledge as 1→2→3→1.
- R5: While wr_req or rd_req is high, in_ready and out_valid are both 0.
- R6: A cell request stays high, with stable index and data, until its acknowledge is sampled. It is low in the cycle after that acknowledge.
- R7: A pop taken while the queue holds more than one entry raises rd_req in the next cycle, with rd_idx equal to the read pointer (1→2→3→1). On rd_ack, rd_data becomes the new head.
- R8: A pop taken while the queue holds exactly one entry empties the queue with no cell access.
- R9: With four entries held, in_ready is 0, and an offered input changes neither the contents nor out_data.
- R10: When a pop and a push are both offered in the same idle cycle, the pop wins. in_ready is 0 in that cycle and the input is not taken.
- R11: Only one of wr_req and rd_req is high at any time, and a raised index always lies in 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a value |
| in_ready | output | 1 | Controller can take the offered value |
| in_data | input | 2 | Value offered |
| out_valid | output | 1 | Head value is available |
| out_ready | input | 1 | Consumer takes the head |
| out_data | output | 2 | Head value |
| wr_req | output | 1 | Cell write request |
| wr_idx | output | 2 | Cell index for the write (1 to 3) |
| wr_data | output | 2 | Value to store |
| wr_ack | input | 1 | Cell write done |
| rd_req | output | 1 | Cell read request |
| rd_idx | output | 2 | Cell index for the read (1 to 3) |
| rd_ack | input | 1 | Cell read done, rd_data valid |
| rd_data | input | 2 | Value returned by the cell |

## Verification
The hardest situations to reach from the ports are pointer wrap-around and a refill read taken exactly when a pointer sits at index 3. The bench gets there by walking a long table of interleaved pushes and pops. Because the queue size varies over the table, the write and read pointers lap the three cells several times at different offsets from each other. A cell model with random acknowledge latency stretches each handshake, so that request hold and stability are observed over several cycles. Directed sequences then fill the queue to four entries, offer a push and a pop in the same cycle, and reset in mid-run to confirm that the pointers restart at 1.

// File: rtl/ringbuf_pkg.sv
`timescale 1ns/1ps
package ringbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } rb_state_e;

endpackage

// File: rtl/ringbuf_ptr.sv
`timescale 1ns/1ps
// Ring pointer over indices 1..NUM_CELLS; resets to 1.
module ringbuf_ptr #(
    parameter int NUM_CELLS = 3,
    parameter int IDX_W     = $clog2(NUM_CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_CELLS);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            idx_d = (idx_q == LAST) ? FIRST : idx_q + FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= FIRST;
        else     idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/ringbuf_evsel.sv
`timescale 1ns/1ps
// Chooses the port event for an idle cycle; a pop outranks a push.
module ringbuf_evsel #(
    parameter int CAP   = 4,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic             idle,
    input  logic [CNT_W-1:0] cnt,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             take_in,
    output logic             take_out
);
    logic not_empty, not_full;

    always_comb begin
        not_empty = (cnt != '0);
        not_full  = (cnt < CNT_W'(CAP));
        out_valid = idle && not_empty;
        take_out  = out_valid && out_ready;
        in_ready  = idle && not_full && !take_out;
        take_in   = in_valid && in_ready;
    end
endmodule

// File: rtl/ringbuf_ctrl.sv
`timescale 1ns/1ps
module ringbuf_ctrl #(
    parameter int DATA_W    = 2,
    parameter int NUM_CELLS = 3,
    localparam int IDX_W    = $clog2(NUM_CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              wr_req,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data
);
    import ringbuf_pkg::*;

    localparam int CAP   = NUM_CELLS + 1;
    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        rb_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] head;
        logic [DATA_W-1:0] wdat;
    } rb_regs_t;

    rb_regs_t regs_d, regs_q;
    logic     take_in, take_out;
    logic     wr_adv, rd_adv;
    logic     idle;

    assign idle = (regs_q.st == ST_IDLE);

    ringbuf_evsel #(.CAP(CAP), .CNT_W(CNT_W)) u_evsel (
        .idle      (idle),
        .cnt       (regs_q.cnt),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .take_in   (take_in),
        .take_out  (take_out)
    );

    ringbuf_ptr #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_wptr (
        .clk (clk), .rst (rst), .adv (wr_adv), .idx (wr_idx)
    );

    ringbuf_ptr #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_rptr (
        .clk (clk), .rst (rst), .adv (rd_adv), .idx (rd_idx)
    );

    always_comb begin
        regs_d = regs_q;
        wr_adv = 1'b0;
        rd_adv = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (take_out) begin
                    if (regs_q.cnt > ONE) regs_d.st  = ST_RD;
                    else                  regs_d.cnt = '0;
                end else if (take_in) begin
                    if (regs_q.cnt == '0) begin
                        regs_d.head = in_data;
                        regs_d.cnt  = ONE;
                    end else begin
                        regs_d.wdat = in_data;
                        regs_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (wr_ack) begin
                    regs_d.cnt = regs_q.cnt + ONE;
                    regs_d.st  = ST_IDLE;
                    wr_adv     = 1'b1;
                end
            end
            ST_RD: begin
                if (rd_ack) begin
                    regs_d.head = rd_data;
                    regs_d.cnt  = regs_q.cnt - ONE;
                    regs_d.st   = ST_IDLE;
                    rd_adv      = 1'b1;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.st   <= ST_IDLE;
            regs_q.cnt  <= '0;
            regs_q.head <= '0;
            regs_q.wdat <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wr_req   = (regs_q.st == ST_WR);
    assign wr_data  = regs_q.wdat;
    assign rd_req   = (regs_q.st == ST_RD);
    assign out_data = regs_q.head;
endmodule

// File: rtl/ringbuf_ctrl_chk.sv
`timescale 1ns/1ps
module ringbuf_ctrl_chk #(
    parameter int DATA_W    = 2,
    parameter int NUM_CELLS = 3,
    parameter int IDX_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              wr_req,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              rd_req,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_ack
);
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data)); // R2

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_req || rd_req) |-> (!in_ready && !out_valid)); // R5

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_idx) && $stable(wr_data))); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_idx))); // R6

    AST_WR_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ack) |=> !wr_req); // R6

    AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack) |=> !rd_req); // R6

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && rd_req)); // R11

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        ((wr_req |-> (wr_idx != '0 && wr_idx <= IDX_W'(NUM_CELLS))) and
         (rd_req |-> (rd_idx != '0 && rd_idx <= IDX_W'(NUM_CELLS))))); // R11
endmodule

bind ringbuf_ctrl ringbuf_ctrl_chk #(
    .DATA_W(DATA_W), .NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .wr_req(wr_req),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req),
    .rd_idx(rd_idx), .rd_ack(rd_ack)
);

// File: tb/ringbuf_ctrl_tb_top.sv
`timescale 1ns/1ps
module ringbuf_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_data = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_data;
    logic       wr_req;
    logic [1:0] wr_idx;
    logic [1:0] wr_data;
    logic       wr_ack = 1'b0;
    logic       rd_req;
    logic [1:0] rd_idx;
    logic       rd_ack = 1'b0;
    logic [1:0] rd_data = '0;

    always #10 clk = ~clk;

    ringbuf_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .wr_req(wr_req), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req),
        .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    // Storage cell model: last written value per index, random latency.
    logic [1:0] cell_mem [1:3];
    int wcnt = 0;
    int rcnt = 0;
    always @(posedge clk) begin
        wr_ack <= 1'b0;
        rd_ack <= 1'b0;
        if (rst) begin
            for (int i = 1; i <= 3; i++) cell_mem[i] <= '0;
            wcnt <= 0;
            rcnt <= 0;
        end else begin
            if (wr_req && !wr_ack) begin
                if (wcnt == 1) begin
                    wr_ack <= 1'b1;
                    cell_mem[wr_idx] <= wr_data;
                    wcnt <= 0;
                end else if (wcnt == 0) wcnt <= int'($urandom_range(3, 0)) + 1;
                else wcnt <= wcnt - 1;
            end
            if (rd_req && !rd_ack) begin
                if (rcnt == 1) begin
                    rd_ack  <= 1'b1;
                    rd_data <= cell_mem[rd_idx];
                    rcnt <= 0;
                end else if (rcnt == 0) rcnt <= int'($urandom_range(3, 0)) + 1;
                else rcnt <= rcnt - 1;
            end
        end
    end

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;
    logic [1:0] model[$];
    int wexp = 1;
    int rexp = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [1:0] v);
        int sz;
        logic [1:0] idx0;
        logic [1:0] dat0;
        sz = model.size();
        @(negedge clk);
        in_data  = v;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (sz == 0) begin
            chk(!wr_req, "R3", int'(wr_req), 0);
            chk(out_valid && out_data == v, "R3", int'(out_data), int'(v));
        end else begin
            chk(wr_req && int'(wr_idx) == wexp && wr_data == v, "R4", int'(wr_idx), wexp);
            chk(!in_ready && !out_valid, "R5", int'(in_ready | out_valid), 0);
            idx0 = wr_idx;
            dat0 = wr_data;
            while (wr_req) begin
                chk(wr_idx == idx0 && wr_data == dat0, "R6", int'(wr_idx), int'(idx0));
                @(negedge clk);
            end
            chk(out_valid, "R2", int'(out_valid), 1);
            wexp = (wexp == 3) ? 1 : wexp + 1;
        end
        model.push_back(v);
    endtask

    task automatic do_pop();
        int sz;
        logic [1:0] idx0;
        sz = model.size();
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        chk(out_data == model[0], "R2", int'(out_data), int'(model[0]));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        if (sz > 1) begin
            chk(rd_req && int'(rd_idx) == rexp, "R7", int'(rd_idx), rexp);
            chk(!in_ready && !out_valid, "R5", int'(in_ready | out_valid), 0);
            idx0 = rd_idx;
            while (rd_req) begin
                chk(rd_idx == idx0, "R6", int'(rd_idx), int'(idx0));
                @(negedge clk);
            end
            chk(out_valid && out_data == model[1], "R7", int'(out_data), int'(model[1]));
            rexp = (rexp == 3) ? 1 : rexp + 1;
        end else begin
            chk(!rd_req && !out_valid, "R8", int'(rd_req | out_valid), 0);
        end
        void'(model.pop_front());
    endtask

    // {op, data}: op 1 = push data, op 0 = pop and compare.
    localparam int NVEC = 22;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b100, 3'b101, 3'b110, 3'b000, 3'b111, 3'b100, 3'b000, 3'b000,
        3'b101, 3'b000, 3'b110, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000,
        3'b110, 3'b000, 3'b101, 3'b111, 3'b000, 3'b000
    };

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model.delete();
        wexp = 1;
        rexp = 1;
    endtask

    initial begin
        logic [1:0] held;
        do_reset();
        @(negedge clk);
        chk(!out_valid && in_ready && !wr_req && !rd_req, "R1",
            int'({out_valid, in_ready, wr_req, rd_req}), 4);

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][2]) do_push(VEC[k][1:0]);
            else           do_pop();
        end

        // Full queue: input offered but refused (R9).
        do_push(2'd3); do_push(2'd1); do_push(2'd2); do_push(2'd0);
        @(negedge clk);
        chk(!in_ready && out_valid, "R9", int'(in_ready), 0);
        held = out_data;
        in_data = 2'd2;
        in_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!wr_req && !in_ready && out_data == held, "R9", int'(wr_req), 0);
        end
        in_valid = 1'b0;
        repeat (4) do_pop();
        @(negedge clk);
        chk(!out_valid && in_ready, "R9", int'(out_valid), 0);

        // Pop and push offered together: pop wins (R10).
        do_push(2'd1);
        @(negedge clk);
        in_data = 2'd2;
        in_valid = 1'b1;
        out_ready = 1'b1;
        #1;
        chk(!in_ready && out_valid, "R10", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        void'(model.pop_front());
        chk(!out_valid && !wr_req && !rd_req, "R10", int'(out_valid | wr_req), 0);

        // Mid-run reset brings pointers back to 1 (R1).
        do_push(2'd2); do_push(2'd3); do_push(2'd1);
        do_pop();
        do_reset();
        @(negedge clk);
        chk(!out_valid && in_ready && !wr_req && !rd_req, "R1",
            int'({out_valid, in_ready, wr_req, rd_req}), 4);
        do_push(2'd0);
        do_push(2'd3); // R1: write pointer back at 1
        do_push(2'd2);
        do_pop();      // R1: read pointer back at 1
        do_pop();
        do_pop();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule